// File: doc/BRIEF.md
# Biphase Line Word Extractor

This block sits behind a data slicer and a bit-clock recovery loop in a video receiver. It reads one line's serial stream as a series of half-bit cells, each marked by a one-cycle enable. The caller qualifies the line with two inputs: a line-select strobe and a first-field flag. While both are high, the block looks for a start code in the half-cells. After a match it decodes biphase-coded bits and groups them into fifteen words.

Five of the fifteen words are kept and the other ten are only counted. The kept bits pass through unchanged, but the word order changes. The four-word group goes to the low end of the output and the single word goes to the top. A single coding violation in any kept bit rejects the whole line. When that happens the output register keeps the last good line, and the error flag reports the rejection alongside the done pulse.

Top module: `biphase_word_extract`

## Requirements
- R1: After reset, `wordOut` is all ones, and `done` and `err` are low.
- R2: Decoding takes place only while both `lineSel` and `firstField` are high. A line with `firstField` low produces no `done` and leaves `wordOut` and `err` unchanged.
- R3: Decoding starts only when the last `START_LEN` half-cells equal `START_PAT`. The earliest of those half-cells is compared with the MSB of `START_PAT`. A line without a matching start code produces no `done`.
- R4: Each bit is two half-cells. The first half-cell gives the bit value, so 1 then 0 encodes a 1 and 0 then 1 encodes a 0.
- R5: Within a word, bits arrive LSB first, and the first bit received lands in bit 0 of its output field.
- R6: Words are numbered 1 to 15, starting with the first bit after the start code. `wordOut` holds the words in this layout, with W = `WORD_BITS`:
  - bits [W-1:0]: word 11
  - bits [2W-1:W]: word 12
  - bits [3W-1:2W]: word 13
  - bits [4W-1:3W]: word 14
  - bits [5W-1:4W]: word 5
- R7: `done` is a single-cycle pulse. It is high in the cycle after the clock edge that follows the edge sampling the second half-cell of the last bit of word 14. There is one pulse per line.
- R8: If two equal half-cells occur in any bit of words 5 or 11 to 14, then at `done` the `err` output is 1 and `wordOut` keeps its previous value.
- R9: Equal half-cells inside words 1–4, 6–10 or 15 are ignored. In that case `err` is 0 at `done` and `wordOut` takes the new line.
- R10: If `lineSel` or `firstField` drops before word 14 is complete, the line is abandoned. No `done` follows and `wordOut` is unchanged.
- R11: `err` changes only together with `done` and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halfEn | input | 1 | One-cycle enable marking each half-bit cell |
| serIn | input | 1 | Sliced serial level, sampled when `halfEn` is high |
| lineSel | input | 1 | High for the duration of the selected line |
| firstField | input | 1 | High during the first field |
| wordOut | output | 5*WORD_BITS | Last error-free assembled word set |
| done | output | 1 | End-of-line pulse |
| err | output | 1 | Status of the line reported by the latest `done` |

## Verification
The bench builds the block with `WORD_BITS` = 4, `START_LEN` = 6 and `START_PAT` = 6'b100110, and leaves the word numbering at its defaults. The narrow words keep each line short. That makes it affordable to inject a single violation at every bit of all fifteen words, sixty lines in all, so every captured position (R8) and every ignored position (R9) is hit. The same configuration is used to run lines with varied data, all-zero and all-ones data, a wrong start code, a deselected field, and drops of the strobe at several word positions.

// File: rtl/bpx_pkg.sv
package bpx_pkg;

  // Maximum number of kept-word slots is 2**SLOT_IDX_W.
  localparam int SLOT_IDX_W = 3;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_HUNT,
    CS_DATA,
    CS_HOLD
  } ctrlState_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic                  lineClr;    // new line: clear start shifter and working bank
    logic                  huntShift;  // shift a half-cell into the start shifter
    logic                  halfA;      // store first half-cell of a bit
    logic                  halfB;      // evaluate second half-cell of a bit
    logic                  capture;    // current word is a kept word
    logic [SLOT_IDX_W-1:0] slot;       // output slot of the current word
    logic                  commit;     // move line result to output bank
  } ctrlStrb_t;

endpackage

// File: rtl/bpx_ctrl.sv
module bpx_ctrl
  import bpx_pkg::*;
#(
  parameter int NUM_WORDS   = 15,
  parameter int WORD_BITS   = 8,
  parameter int GROUP_FIRST = 11,
  parameter int GROUP_LEN   = 4,
  parameter int SOLO_WORD   = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      halfEn,
  input  logic      lineSel,
  input  logic      firstField,
  input  logic      startHit,
  output ctrlStrb_t strb,
  output logic      done
);

  localparam int BIT_CW    = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam int WORD_CW   = $clog2(NUM_WORDS + 1);
  localparam int LAST_WORD = GROUP_FIRST + GROUP_LEN - 1;

  localparam logic [BIT_CW-1:0]  BIT_LAST = BIT_CW'(WORD_BITS - 1);
  localparam logic [WORD_CW-1:0] W_LAST   = WORD_CW'(LAST_WORD);
  localparam logic [WORD_CW-1:0] W_GFIRST = WORD_CW'(GROUP_FIRST);
  localparam logic [WORD_CW-1:0] W_GEND   = WORD_CW'(GROUP_FIRST + GROUP_LEN);
  localparam logic [WORD_CW-1:0] W_SOLO   = WORD_CW'(SOLO_WORD);
  localparam logic [WORD_CW-1:0] W_ONE    = WORD_CW'(1);

  ctrlState_e          state, nextState;
  logic                phase;
  logic [BIT_CW-1:0]   bitCnt;
  logic [WORD_CW-1:0]  wordNo;
  logic                finish, finishQ, doneR;
  logic                active, inGroup, isSolo, lastBit;
  logic [WORD_CW-1:0]  grpOff;
  logic [SLOT_IDX_W-1:0] slotSel;

  always_comb begin
    active  = lineSel & firstField;
    inGroup = (wordNo >= W_GFIRST) && (wordNo < W_GEND);
    isSolo  = (wordNo == W_SOLO);
    lastBit = (bitCnt == BIT_LAST);
    grpOff  = wordNo - W_GFIRST;
    slotSel = isSolo ? SLOT_IDX_W'(GROUP_LEN) : SLOT_IDX_W'(grpOff);
  end

  always_comb begin
    nextState = state;
    finish    = 1'b0;
    strb      = '0;
    strb.slot   = slotSel;
    strb.commit = finishQ;
    unique case (state)
      CS_IDLE: begin
        if (active) begin
          nextState    = CS_HUNT;
          strb.lineClr = 1'b1;
        end
      end
      CS_HUNT: begin
        if (!active) begin
          nextState = CS_IDLE;
        end else if (halfEn) begin
          strb.huntShift = 1'b1;
          if (startHit) nextState = CS_DATA;
        end
      end
      CS_DATA: begin
        if (!active) begin
          nextState = CS_IDLE;
        end else if (halfEn) begin
          if (!phase) begin
            strb.halfA = 1'b1;
          end else begin
            strb.halfB   = 1'b1;
            strb.capture = inGroup | isSolo;
            if (lastBit && (wordNo == W_LAST)) begin
              finish    = 1'b1;
              nextState = CS_HOLD;
            end
          end
        end
      end
      CS_HOLD: begin
        if (!active) nextState = CS_IDLE;
      end
      default: nextState = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= CS_IDLE;
      phase   <= 1'b0;
      bitCnt  <= '0;
      wordNo  <= W_ONE;
      finishQ <= 1'b0;
      doneR   <= 1'b0;
    end else begin
      state   <= nextState;
      finishQ <= finish;
      doneR   <= finishQ;
      if (strb.huntShift) begin
        phase  <= 1'b0;
        bitCnt <= '0;
        wordNo <= W_ONE;
      end else if (strb.halfA) begin
        phase <= 1'b1;
      end else if (strb.halfB) begin
        phase <= 1'b0;
        if (lastBit) begin
          bitCnt <= '0;
          wordNo <= wordNo + W_ONE;
        end else begin
          bitCnt <= bitCnt + BIT_CW'(1);
        end
      end
    end
  end

  assign done = doneR;

endmodule

// File: rtl/bpx_dpath.sv
module bpx_dpath
  import bpx_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int SLOTS     = 5,
  parameter int START_LEN = 16,
  parameter logic [START_LEN-1:0] START_PAT = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serIn,
  input  logic                       halfEn,
  input  ctrlStrb_t                  strb,
  output logic                       startHit,
  output logic [SLOTS*WORD_BITS-1:0] wordOut,
  output logic                       err
);

  localparam int OUT_W = SLOTS * WORD_BITS;

  logic [START_LEN-1:0] startShift, startNext;
  logic                 firstHalf;
  logic                 lineErr;
  logic                 violation;
  logic [OUT_W-1:0]     workBank;
  logic [OUT_W-1:0]     outBank;
  logic                 errR;

  always_comb begin
    startNext = {startShift[START_LEN-2:0], serIn};
    startHit  = halfEn && (startNext == START_PAT);
    violation = strb.halfB && (firstHalf == serIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startShift <= '0;
      firstHalf  <= 1'b0;
      lineErr    <= 1'b0;
    end else begin
      if (strb.lineClr)        startShift <= '0;
      else if (strb.huntShift) startShift <= startNext;
      if (strb.halfA) firstHalf <= serIn;
      if (strb.lineClr)                         lineErr <= 1'b0;
      else if (violation && strb.capture)       lineErr <= 1'b1;
    end
  end

  // One shift register per kept word; first bit received ends at bit 0.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [WORD_BITS-1:0] slotReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotReg <= '0;
      end else if (strb.lineClr) begin
        slotReg <= '0;
      end else if (strb.capture && (strb.slot == SLOT_IDX_W'(s))) begin
        if (WORD_BITS > 1) slotReg <= {firstHalf, slotReg[WORD_BITS-1:1]};
        else               slotReg <= firstHalf;
      end
    end
    assign workBank[s*WORD_BITS +: WORD_BITS] = slotReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBank <= '1;
      errR    <= 1'b0;
    end else if (strb.commit) begin
      errR <= lineErr;
      if (!lineErr) outBank <= workBank;
    end
  end

  assign wordOut = outBank;
  assign err     = errR;

endmodule

// File: rtl/biphase_word_extract.sv
module biphase_word_extract
  import bpx_pkg::*;
#(
  parameter int NUM_WORDS   = 15,
  parameter int WORD_BITS   = 8,
  parameter int GROUP_FIRST = 11,
  parameter int GROUP_LEN   = 4,
  parameter int SOLO_WORD   = 5,
  parameter int START_LEN   = 16,
  parameter logic [START_LEN-1:0] START_PAT = 16'b1001_1010_1100_0101
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               halfEn,
  input  logic                               serIn,
  input  logic                               lineSel,
  input  logic                               firstField,
  output logic [(GROUP_LEN+1)*WORD_BITS-1:0] wordOut,
  output logic                               done,
  output logic                               err
);

  localparam int SLOTS = GROUP_LEN + 1;

  ctrlStrb_t strb;
  logic      startHit;

  bpx_ctrl #(
    .NUM_WORDS  (NUM_WORDS),
    .WORD_BITS  (WORD_BITS),
    .GROUP_FIRST(GROUP_FIRST),
    .GROUP_LEN  (GROUP_LEN),
    .SOLO_WORD  (SOLO_WORD)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .halfEn    (halfEn),
    .lineSel   (lineSel),
    .firstField(firstField),
    .startHit  (startHit),
    .strb      (strb),
    .done      (done)
  );

  bpx_dpath #(
    .WORD_BITS(WORD_BITS),
    .SLOTS    (SLOTS),
    .START_LEN(START_LEN),
    .START_PAT(START_PAT)
  ) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .serIn   (serIn),
    .halfEn  (halfEn),
    .strb    (strb),
    .startHit(startHit),
    .wordOut (wordOut),
    .err     (err)
  );

endmodule

// File: rtl/bpx_checker.sv
module bpx_checker #(
  parameter int OUT_W = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             done,
  input logic             err,
  input logic [OUT_W-1:0] wordOut
);

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_err_keeps_word: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> $stable(wordOut));

  a_r10_word_moves_with_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordOut) |-> done);

  a_r11_err_holds: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(err));

endmodule

bind biphase_word_extract bpx_checker #(.OUT_W(SLOTS * WORD_BITS)) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .done   (done),
  .err    (err),
  .wordOut(wordOut)
);

// File: tb/test_biphase_word_extract.sv
module test_biphase_word_extract;

  localparam int W  = 4;
  localparam int SL = 6;
  localparam logic [SL-1:0] PAT = 6'b100110;
  localparam int OW = 5 * W;

  logic          clk = 1'b0;
  logic          rstN, halfEn, serIn, lineSel, firstField;
  logic [OW-1:0] wordOut;
  logic          done, err;

  logic [W-1:0] lineData [1:15];
  int vectors = 0, miscompares = 0;
  int cyc = 0, doneCnt = 0, doneCyc = 0, tgtCyc = 0, lastCyc = 0;

  biphase_word_extract #(
    .WORD_BITS(W), .START_LEN(SL), .START_PAT(PAT)
  ) i_biphase_word_extract (
    .clk(clk), .rstN(rstN), .halfEn(halfEn), .serIn(serIn),
    .lineSel(lineSel), .firstField(firstField),
    .wordOut(wordOut), .done(done), .err(err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rstN && done) begin
    doneCnt = doneCnt + 1;
    doneCyc = cyc;
  end

  always @(posedge clk) if (cyc > 150000) begin
    miscompares = miscompares + 1;
    $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      miscompares = miscompares + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] expWord();
    logic [OW-1:0] v;
    for (int s = 0; s < 4; s++) v[s*W +: W] = lineData[11+s];
    v[4*W +: W] = lineData[5];
    return v;
  endfunction

  task automatic fillData(input int seed);
    for (int w = 1; w <= 15; w++) lineData[w] = W'(w * (seed + 3) + seed * 7 + (seed >> 2));
  endtask

  task automatic sendHalf(input logic b);
    serIn  = b;
    halfEn = 1'b1;
    @(negedge clk);
    halfEn  = 1'b0;
    lastCyc = cyc;
    @(negedge clk);
  endtask

  task automatic runLine(input bit ff, input bit badStart, input int errWord,
                         input int errBit, input int abortWord);
    bit   aborted = 0;
    logic bv;
    @(negedge clk);
    lineSel = 1'b1; firstField = ff;
    repeat (2) @(negedge clk);
    repeat (3) sendHalf(1'b0);
    for (int i = SL - 1; i >= 0; i--) begin
      bv = PAT[i];
      if (badStart && i == 0) bv = ~bv;
      sendHalf(bv);
    end
    for (int w = 1; w <= 15 && !aborted; w++) begin
      if (w == abortWord) begin
        aborted = 1;
        lineSel = 1'b0;
      end else begin
        for (int b = 0; b < W; b++) begin
          bv = lineData[w][b];
          sendHalf(bv);
          sendHalf((w == errWord && b == errBit) ? bv : ~bv);
          if (w == 14 && b == W - 1) tgtCyc = lastCyc;
        end
      end
    end
    lineSel = 1'b0; firstField = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Good line: one done at the right cycle, err and word as expected.
  task automatic expectDone(input string tag, input logic [OW-1:0] expOut,
                            input logic expErr, input int cntBefore);
    check({tag, " R7 done count"}, 64'(doneCnt - cntBefore), 64'd1);
    check({tag, " R7 done cycle"}, 64'(doneCyc), 64'(tgtCyc + 1));
    check({tag, " err"}, 64'(err), 64'(expErr));
    check({tag, " wordOut"}, 64'(wordOut), 64'(expOut));
  endtask

  task automatic expectNone(input string tag, input logic [OW-1:0] prevOut,
                            input logic prevErr, input int cntBefore);
    check({tag, " no done"}, 64'(doneCnt - cntBefore), 64'd0);
    check({tag, " wordOut held"}, 64'(wordOut), 64'(prevOut));
    check({tag, " R11 err held"}, 64'(err), 64'(prevErr));
  endtask

  initial begin
    logic [OW-1:0] prevOut;
    logic          prevErr;
    int            cnt;
    bit            kept;
    rstN = 1'b0; halfEn = 1'b0; serIn = 1'b0; lineSel = 1'b0; firstField = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 wordOut reset", 64'(wordOut), 64'((1 << OW) - 1));
    check("R1 done reset", 64'(done), 64'd0);
    check("R1 err reset", 64'(err), 64'd0);

    // Data sweep plus all-zero and all-ones lines (R4 R5 R6).
    for (int seed = 0; seed < 14; seed++) begin
      if (seed == 12)      for (int w = 1; w <= 15; w++) lineData[w] = '1;
      else if (seed == 13) for (int w = 1; w <= 15; w++) lineData[w] = '0;
      else                 fillData(seed);
      cnt = doneCnt;
      runLine(1, 0, 0, 0, 0);
      expectDone("R4 R6 data", expWord(), 1'b0, cnt);
      check("R5 lsb-first word11", 64'(wordOut[W-1:0]), 64'(lineData[11]));
      check("R6 word5 on top", 64'(wordOut[OW-1 -: W]), 64'(lineData[5]));
    end

    // Violation at every bit of every word (R8 captured, R9 ignored).
    for (int w = 1; w <= 15; w++) begin
      for (int b = 0; b < W; b++) begin
        fillData(20 + w * W + b);
        kept    = (w == 5) || (w >= 11 && w <= 14);
        prevOut = wordOut;
        cnt     = doneCnt;
        runLine(1, 0, w, b, 0);
        if (kept) expectDone("R8 kept violation", prevOut, 1'b1, cnt);
        else      expectDone("R9 ignored violation", expWord(), 1'b0, cnt);
      end
    end

    // err is 1 here; unselected field and bad start leave everything alone.
    fillData(200);
    runLine(1, 0, 12, 1, 0);
    prevOut = wordOut; prevErr = err;
    check("R8 err set before hold tests", 64'(err), 64'd1);
    fillData(201); cnt = doneCnt;
    runLine(0, 0, 0, 0, 0);
    expectNone("R2 second field", prevOut, prevErr, cnt);
    for (int w = 1; w <= 15; w++) lineData[w] = '0;
    cnt = doneCnt;
    runLine(1, 1, 0, 0, 0);
    expectNone("R3 bad start", prevOut, prevErr, cnt);

    // Early loss of the strobe at several positions (R10).
    for (int k = 0; k < 4; k++) begin
      int ab;
      ab = (k == 0) ? 1 : (k == 1) ? 6 : (k == 2) ? 12 : 14;
      fillData(300 + k); cnt = doneCnt;
      runLine(1, 0, 0, 0, ab);
      expectNone("R10 abort", prevOut, prevErr, cnt);
    end

    fillData(400); cnt = doneCnt;
    runLine(1, 0, 0, 0, 0);
    expectDone("R10 recovery", expWord(), 1'b0, cnt);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule